// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block is the digital core behind four 256-position resistor wipers. Each channel keeps a volatile 8-bit tap register, and only that register sets the wiper position. Each channel also keeps a bank of four saved-position registers. The saved registers are ordinary flops here, and each takes a parameterised value at reset.

The first way to move a wiper is a pin-level stepping interface. A two-bit channel select picks one wiper, and a direction pin sets up or down. An active-low enable gates the interface, and a rising edge on the step input moves the selected wiper by one tap. The second way is a parallel request port, which stands in for a serial bus. It can write or read a tap register, write or read any saved register, and copy a value between a saved register and the tap register in either direction.

A write-protect input guards the saved registers. After reset is released, every tap register reloads from saved slot 0 of its own channel.

Top module: `qwr_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge all four tap registers become 0 and `rsp_valid` becomes 0.
- R2: The first clock edge with `rst` low loads each tap register from saved slot 0 of its channel. The default saved values are 0xFE, 0x01, 0x80 and 0x3C in slot 0 of channels 0 to 3. Slot s>0 of channel c holds 0x20 + 0x10*c + s.
- R3: A step happens when the sampled `step_in` is 0 at one edge and 1 at the next, with `step_en_n` low. At that second edge the channel on `step_sel` moves one tap. It moves up when `step_up` is 1 and down when `step_up` is 0.
- R4: Stepping saturates, with no wrap: a step up at 255 leaves 255, and a step down at 0 leaves 0.
- R5: A rising step edge with `step_en_n` high changes no tap register. A step never changes a channel other than the one selected.
- R6: A request presented with `req_valid` at one edge is answered one cycle later with `rsp_valid` high. The operation codes on `req_op` are: 0 write tap, 1 read tap, 2 write saved, 3 read saved, 4 saved-to-tap, 5 tap-to-saved. A read returns the addressed value on `rsp_rdata`.
- R7: Write saved (op 2) stores `req_wdata` in slot `req_idx` of channel `req_ch`, and read saved (op 3) returns it.
- R8: Saved-to-tap (op 4) copies the addressed saved slot into the channel's tap register. Tap-to-saved (op 5) copies the tap value from before the edge into the addressed slot.
- R9: With `wp` high, ops 2 and 5 return `rsp_err`=1 and change nothing. Ops 0 and 4 still complete with no error.
- R10: Op codes 6 and 7 return `rsp_err`=1 and change no register.
- R11: A tap write by op 0 or op 4 takes precedence over a step that lands on the same channel at the same edge.
- R12: In the recall cycle (the first edge after reset), a request is answered with `rsp_err`=1 and has no effect, and a step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up model) |
| step_in | input | 1 | Step strobe; a rising sample triggers a step |
| step_en_n | input | 1 | Active-low enable of the stepping interface |
| step_up | input | 1 | Step direction, 1 = up |
| step_sel | input | 2 | Channel acted on by the stepping interface |
| wp | input | 1 | Write protect for the saved registers |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_ch | input | 2 | Addressed channel |
| req_idx | input | 2 | Addressed saved slot |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 8 | Read data, 0 for non-read operations |
| rsp_err | output | 1 | Request rejected |
| wiper_pos | output | 32 | Tap registers, channel c at bits [8c+7:8c] |

## Verification
The stepping path is checked with full climbs and descents of one channel across all 256 taps, including the steps at each end. This shows a saturating counter apart from a wrapping or off-by-one one. Every channel and every tap value is written and read back through the request port, and every saved slot gets a distinct value, so an aliased channel or slot decode shows as a miscompare. Protected, undefined and recall-cycle requests are checked by reading the targeted registers back. Coincident step and port writes are run on the same channel and on different channels to expose the priority between them.

// File: rtl/qwr_pkg.sv
package qwr_pkg;

  localparam int unsigned TAP_W = 8;

  typedef enum logic [2:0] {
    OP_WR_TAP   = 3'd0,
    OP_RD_TAP   = 3'd1,
    OP_WR_SAVE  = 3'd2,
    OP_RD_SAVE  = 3'd3,
    OP_SAVE2TAP = 3'd4,
    OP_TAP2SAVE = 3'd5
  } qwr_op_e;

  // One saturating step of a tap register.
  function automatic logic [TAP_W-1:0] sat_step(input logic [TAP_W-1:0] v, input logic up);
    logic [TAP_W-1:0] one;
    one = {{(TAP_W-1){1'b0}}, 1'b1};
    if (up) return (v == {TAP_W{1'b1}}) ? v : v + one;
    else    return (v == '0) ? v : v - one;
  endfunction

  function automatic logic [TAP_W-1:0] slot0_default(input int c);
    case (c)
      0:       return 8'hFE;
      1:       return 8'h01;
      2:       return 8'h80;
      3:       return 8'h3C;
      default: return 8'h80;
    endcase
  endfunction

  // Default saved-register image; channel c slot s at entry c*nslot+s.
  function automatic logic [1023:0] dr_default(input int nch, input int nslot);
    logic [1023:0] r;
    r = '0;
    for (int c = 0; c < nch; c++) begin
      for (int s = 0; s < nslot; s++) begin
        if ((c * nslot + s) < 128) begin
          if (s == 0) r[(c*nslot+s)*TAP_W +: TAP_W] = slot0_default(c);
          else        r[(c*nslot+s)*TAP_W +: TAP_W] = TAP_W'(32 + 16*c + s);
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/qwr_updn.sv
module qwr_updn #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_in,
  input  logic           step_en_n,
  input  logic           step_up,
  input  logic [CHW-1:0] step_sel,
  input  logic           block,
  output logic [NCH-1:0] step_ev,
  output logic           step_dir
);

  logic step_q;
  logic fire;

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= step_in;
  end

  assign fire     = step_in & ~step_q & ~step_en_n & ~block;
  assign step_dir = step_up;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign step_ev[i] = fire && (step_sel == CHW'(i));
  end

endmodule

// File: rtl/qwr_channel.sv
module qwr_channel
  import qwr_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter logic [NSLOT*TAP_W-1:0] INIT = '0,
  localparam int unsigned IDXW = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   recall,
  input  logic                   step_en,
  input  logic                   step_up,
  input  logic                   tap_we,
  input  logic [TAP_W-1:0]       tap_d,
  input  logic                   save_we,
  input  logic [IDXW-1:0]        save_idx,
  input  logic [TAP_W-1:0]       save_d,
  output logic [TAP_W-1:0]       tap,
  output logic [NSLOT*TAP_W-1:0] saved
);

  // Tap register: recall, then port write, then step.
  always_ff @(posedge clk) begin
    if (rst)          tap <= '0;
    else if (recall)  tap <= saved[TAP_W-1:0];
    else if (tap_we)  tap <= tap_d;
    else if (step_en) tap <= sat_step(tap, step_up);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) saved[s*TAP_W +: TAP_W] <= INIT[s*TAP_W +: TAP_W];
      else if (save_we && save_idx == IDXW'(s)) saved[s*TAP_W +: TAP_W] <= save_d;
    end
  end

endmodule

// File: rtl/qwr_regport.sv
module qwr_regport
  import qwr_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned NSLOT = 4,
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned IDXW = $clog2(NSLOT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       recall,
  input  logic                       wp,
  input  logic                       req_valid,
  input  logic [2:0]                 req_op,
  input  logic [CHW-1:0]             req_ch,
  input  logic [IDXW-1:0]            req_idx,
  input  logic [TAP_W-1:0]           req_wdata,
  input  logic [NCH*TAP_W-1:0]       taps,
  input  logic [NCH*NSLOT*TAP_W-1:0] saved_all,
  output logic [NCH-1:0]             tap_we,
  output logic [TAP_W-1:0]           tap_d,
  output logic [NCH-1:0]             save_we,
  output logic [IDXW-1:0]            save_idx,
  output logic [TAP_W-1:0]           save_d,
  output logic                       rsp_valid,
  output logic [TAP_W-1:0]           rsp_rdata,
  output logic                       rsp_err
);

  logic             acc;
  logic             any_tap_we, any_save_we, err_c;
  logic [TAP_W-1:0] rd_c, cur_tap, cur_save;

  assign acc      = req_valid & ~recall;
  assign cur_tap  = taps[req_ch*TAP_W +: TAP_W];
  assign cur_save = saved_all[(req_ch*NSLOT + req_idx)*TAP_W +: TAP_W];
  assign save_idx = req_idx;

  always_comb begin
    any_tap_we  = 1'b0;
    any_save_we = 1'b0;
    err_c       = 1'b0;
    rd_c        = '0;
    tap_d       = req_wdata;
    save_d      = req_wdata;
    case (req_op)
      OP_WR_TAP:   any_tap_we = 1'b1;
      OP_RD_TAP:   rd_c = cur_tap;
      OP_WR_SAVE:  if (wp) err_c = 1'b1; else any_save_we = 1'b1;
      OP_RD_SAVE:  rd_c = cur_save;
      OP_SAVE2TAP: begin any_tap_we = 1'b1; tap_d = cur_save; end
      OP_TAP2SAVE: begin
        save_d = cur_tap;
        if (wp) err_c = 1'b1; else any_save_we = 1'b1;
      end
      default:     err_c = 1'b1;
    endcase
    if (recall) begin
      any_tap_we  = 1'b0;
      any_save_we = 1'b0;
      err_c       = 1'b1;
      rd_c        = '0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_we
    assign tap_we[i]  = acc && any_tap_we  && (req_ch == CHW'(i));
    assign save_we[i] = acc && any_save_we && (req_ch == CHW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_c : '0;
      rsp_err   <= req_valid & err_c;
    end
  end

endmodule

// File: rtl/qwr_ctrl.sv
module qwr_ctrl
  import qwr_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned NSLOT = 4,
  parameter logic [1023:0] DR_INIT = qwr_pkg::dr_default(NCH, NSLOT),
  localparam int unsigned CHW  = $clog2(NCH),
  localparam int unsigned IDXW = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_in,
  input  logic                   step_en_n,
  input  logic                   step_up,
  input  logic [CHW-1:0]         step_sel,
  input  logic                   wp,
  input  logic                   req_valid,
  input  logic [2:0]             req_op,
  input  logic [CHW-1:0]         req_ch,
  input  logic [IDXW-1:0]        req_idx,
  input  logic [TAP_W-1:0]       req_wdata,
  output logic                   rsp_valid,
  output logic [TAP_W-1:0]       rsp_rdata,
  output logic                   rsp_err,
  output logic [NCH*TAP_W-1:0]   wiper_pos
);

  // Named internal events, also watched by the checker.
  logic                       recall_q;
  logic [NCH-1:0]             step_ev;
  logic                       step_dir;
  logic [NCH-1:0]             tap_we;
  logic [TAP_W-1:0]           tap_d;
  logic [NCH-1:0]             save_we;
  logic [IDXW-1:0]            save_idx;
  logic [TAP_W-1:0]           save_d;
  logic [NCH*NSLOT*TAP_W-1:0] saved_all;
  logic [NCH*TAP_W-1:0]       dr_slot0;

  always_ff @(posedge clk) begin
    if (rst) recall_q <= 1'b1;
    else     recall_q <= 1'b0;
  end

  qwr_updn #(.NCH(NCH)) u_updn (
    .clk(clk), .rst(rst), .step_in(step_in), .step_en_n(step_en_n),
    .step_up(step_up), .step_sel(step_sel), .block(recall_q),
    .step_ev(step_ev), .step_dir(step_dir)
  );

  qwr_regport #(.NCH(NCH), .NSLOT(NSLOT)) u_port (
    .clk(clk), .rst(rst), .recall(recall_q), .wp(wp),
    .req_valid(req_valid), .req_op(req_op), .req_ch(req_ch),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .taps(wiper_pos), .saved_all(saved_all),
    .tap_we(tap_we), .tap_d(tap_d), .save_we(save_we),
    .save_idx(save_idx), .save_d(save_d),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qwr_channel #(
      .NSLOT(NSLOT),
      .INIT(DR_INIT[c*NSLOT*TAP_W +: NSLOT*TAP_W])
    ) u_ch (
      .clk(clk), .rst(rst), .recall(recall_q),
      .step_en(step_ev[c]), .step_up(step_dir),
      .tap_we(tap_we[c]), .tap_d(tap_d),
      .save_we(save_we[c]), .save_idx(save_idx), .save_d(save_d),
      .tap(wiper_pos[c*TAP_W +: TAP_W]),
      .saved(saved_all[c*NSLOT*TAP_W +: NSLOT*TAP_W])
    );
    assign dr_slot0[c*TAP_W +: TAP_W] = saved_all[c*NSLOT*TAP_W +: TAP_W];
  end

endmodule

// File: rtl/qwr_ctrl_chk.sv
module qwr_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           recall_q,
  input logic           step_en_n,
  input logic           wp,
  input logic           req_valid,
  input logic [2:0]     req_op,
  input logic [NCH-1:0] step_ev,
  input logic           step_dir,
  input logic [NCH-1:0] tap_we,
  input logic [NCH*W-1:0] wiper_pos,
  input logic [NCH*W-1:0] dr_slot0,
  input logic           rsp_valid,
  input logic           rsp_err
);

  assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && wp && (req_op == 3'd2 || req_op == 3'd5)) |=> rsp_err);

  assert_undef_op_err_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd6 || req_op == 3'd7)) |=> rsp_err);

  assert_recall_req_err_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && recall_q) |=> rsp_err);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_recall_load_R2: assert property (@(posedge clk) disable iff (rst)
      recall_q |=> wiper_pos[c*W +: W] == $past(dr_slot0[c*W +: W]));

    assert_single_tap_move_R3: assert property (@(posedge clk) disable iff (rst)
      (!tap_we[c] && !recall_q) |=>
        (wiper_pos[c*W +: W] == $past(wiper_pos[c*W +: W])) ||
        (wiper_pos[c*W +: W] == $past(wiper_pos[c*W +: W]) + W'(1)) ||
        (wiper_pos[c*W +: W] == $past(wiper_pos[c*W +: W]) - W'(1)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
      (step_ev[c] && step_dir && !tap_we[c] && wiper_pos[c*W +: W] == {W{1'b1}})
        |=> wiper_pos[c*W +: W] == {W{1'b1}});

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
      (step_ev[c] && !step_dir && !tap_we[c] && wiper_pos[c*W +: W] == '0)
        |=> wiper_pos[c*W +: W] == '0);

    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (step_en_n && !tap_we[c] && !recall_q) |=>
        wiper_pos[c*W +: W] == $past(wiper_pos[c*W +: W]));
  end

endmodule

bind qwr_ctrl qwr_ctrl_chk #(.NCH(NCH), .W(qwr_pkg::TAP_W)) u_chk (
  .clk(clk), .rst(rst), .recall_q(recall_q), .step_en_n(step_en_n),
  .wp(wp), .req_valid(req_valid), .req_op(req_op), .step_ev(step_ev),
  .step_dir(step_dir), .tap_we(tap_we), .wiper_pos(wiper_pos),
  .dr_slot0(dr_slot0), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/qwr_ctrl_tb.sv
module qwr_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b0, step_en_n = 1'b1, step_up = 1'b0, wp = 1'b0;
  logic [1:0] step_sel = '0, req_ch = '0, req_idx = '0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic [31:0] wiper_pos;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_tap [4];
  logic [7:0] m_sav [4][4];

  always #2 clk = ~clk;

  qwr_ctrl u_dut (
    .clk(clk), .rst(rst), .step_in(step_in), .step_en_n(step_en_n),
    .step_up(step_up), .step_sel(step_sel), .wp(wp),
    .req_valid(req_valid), .req_op(req_op), .req_ch(req_ch),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .wiper_pos(wiper_pos)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] def_val(input int c, input int s);
    logic [7:0] t [4];
    t[0] = 8'hFE; t[1] = 8'h01; t[2] = 8'h80; t[3] = 8'h3C;
    return (s == 0) ? t[c] : 8'(8'h20 + 16 * c + s);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_tap[c] = def_val(c, 0);
      for (int s = 0; s < 4; s++) m_sav[c][s] = def_val(c, s);
    end
  endtask

  task automatic chk_taps(input string tag);
    for (int c = 0; c < 4; c++) chk(tag, int'(wiper_pos[c*8 +: 8]), int'(m_tap[c]));
  endtask

  task automatic step(input int c, input bit up, input string tag);
    step_sel = 2'(c); step_up = up; step_en_n = 1'b0; step_in = 1'b1;
    cyc();
    step_in = 1'b0;
    if (up) m_tap[c] = (m_tap[c] == 8'hFF) ? 8'hFF : m_tap[c] + 8'd1;
    else    m_tap[c] = (m_tap[c] == 8'h00) ? 8'h00 : m_tap[c] - 8'd1;
    chk_taps(tag);
    cyc();
    step_en_n = 1'b1;
  endtask

  task automatic port(input int op, input int c, input int idx, input int wd,
                      input bit exp_err, input bit do_rd, input int exp_rd,
                      input string tag);
    req_valid = 1'b1; req_op = 3'(op); req_ch = 2'(c);
    req_idx = 2'(idx); req_wdata = 8'(wd);
    cyc();
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " rsp_err"}, int'(rsp_err), int'(exp_err));
    if (do_rd) chk({tag, " rdata"}, int'(rsp_rdata), exp_rd);
  endtask

  task automatic chk_all_saved(input string tag);
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        port(3, c, s, 0, 1'b0, 1'b1, int'(m_sav[c][s]), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) cyc();
    // R1: reset state
    chk("R1 tap0", int'(wiper_pos), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);

    // R2: recall from slot 0
    rst = 1'b0;
    cyc();
    chk_taps("R2 recall");
    chk_all_saved("R2 R7 default saved");

    // R3/R4: single steps and saturation
    step(0, 1'b1, "R3 up ch0");
    step(0, 1'b1, "R4 sat high ch0");
    step(1, 1'b0, "R3 down ch1");
    step(1, 1'b0, "R4 sat low ch1");
    step(2, 1'b1, "R3 up ch2");
    step(2, 1'b0, "R3 down ch2");

    // R5: disabled interface
    step_sel = 2'd3; step_up = 1'b1; step_en_n = 1'b1; step_in = 1'b1;
    cyc(); step_in = 1'b0; cyc();
    chk_taps("R5 disabled step");

    // R3/R4 sweep on channel 3 across full range
    port(0, 3, 0, 0, 1'b0, 1'b0, 0, "R6 wr tap");
    m_tap[3] = 8'h00;
    for (int k = 0; k < 256; k++) step(3, 1'b1, "R3 R4 climb");
    for (int k = 0; k < 256; k++) step(3, 1'b0, "R3 R4 descend");

    // R6: tap write/read, every value, rotating channel
    for (int v = 0; v < 256; v++) begin
      int c;
      c = v % 4;
      port(0, c, 0, v, 1'b0, 1'b0, 0, "R6 wr tap");
      m_tap[c] = 8'(v);
      port(1, c, 0, 0, 1'b0, 1'b1, v, "R6 rd tap");
    end
    chk_taps("R6 taps");

    // R7: saved write/read, distinct per slot
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) begin
        m_sav[c][s] = 8'((c * 4 + s) * 13 + 7);
        port(2, c, s, int'(m_sav[c][s]), 1'b0, 1'b0, 0, "R7 wr saved");
      end
    chk_all_saved("R7 rd saved");

    // R8: transfers
    port(4, 1, 2, 0, 1'b0, 1'b0, 0, "R8 save2tap");
    m_tap[1] = m_sav[1][2];
    chk_taps("R8 save2tap taps");
    port(5, 2, 3, 0, 1'b0, 1'b0, 0, "R8 tap2save");
    m_sav[2][3] = m_tap[2];
    chk_all_saved("R8 tap2save");

    // R9: write protect
    wp = 1'b1;
    port(2, 0, 1, 8'hA5, 1'b1, 1'b0, 0, "R9 wr saved blocked");
    port(5, 3, 2, 0, 1'b1, 1'b0, 0, "R9 tap2save blocked");
    port(0, 0, 0, 8'h5A, 1'b0, 1'b0, 0, "R9 wr tap allowed");
    m_tap[0] = 8'h5A;
    port(4, 3, 1, 0, 1'b0, 1'b0, 0, "R9 save2tap allowed");
    m_tap[3] = m_sav[3][1];
    chk_taps("R9 taps");
    chk_all_saved("R9 saved unchanged");
    wp = 1'b0;

    // R10: undefined op codes
    port(6, 1, 1, 8'h33, 1'b1, 1'b0, 0, "R10 op6");
    port(7, 2, 0, 8'h44, 1'b1, 1'b0, 0, "R10 op7");
    chk_taps("R10 taps");
    chk_all_saved("R10 saved");

    // R11: port write vs step on same channel, and on other channel
    step_sel = 2'd2; step_up = 1'b1; step_en_n = 1'b0; step_in = 1'b1;
    req_valid = 1'b1; req_op = 3'd0; req_ch = 2'd2; req_wdata = 8'h11;
    cyc();
    req_valid = 1'b0; step_in = 1'b0;
    m_tap[2] = 8'h11;
    chk_taps("R11 same channel");
    cyc();
    step_in = 1'b1; step_sel = 2'd1;
    req_valid = 1'b1; req_op = 3'd0; req_ch = 2'd0; req_wdata = 8'h22;
    cyc();
    req_valid = 1'b0; step_in = 1'b0; step_en_n = 1'b1;
    m_tap[0] = 8'h22;
    m_tap[1] = (m_tap[1] == 8'hFF) ? 8'hFF : m_tap[1] + 8'd1;
    chk_taps("R11 other channel");
    cyc();

    // R12: request and step in the recall cycle
    rst = 1'b1;
    repeat (2) cyc();
    model_reset();
    rst = 1'b0;
    step_sel = 2'd0; step_up = 1'b0; step_en_n = 1'b0; step_in = 1'b1;
    req_valid = 1'b1; req_op = 3'd0; req_ch = 2'd0; req_wdata = 8'h55;
    cyc();
    req_valid = 1'b0;
    chk("R12 rsp_err", int'(rsp_err), 1);
    chk_taps("R12 recall wins");
    step_in = 1'b0; step_en_n = 1'b1;
    cyc();
    chk_taps("R12 later");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule